// File: doc/BRIEF.md
# Serial Transport-Overhead Byte Port

This block gives an external device a slow two-wire serial path to the transport-overhead bytes of each frame, in both directions. On the transmit side it drives a divided clock and samples a serial data line to collect overhead bytes. In the next frame it offers those bytes to the frame multiplexer, one byte at each matching overhead position. On the receive side it captures overhead bytes that the demultiplexer extracts from the incoming frame. In the next frame it shifts them out on its own divided clock.

A 2-bit mode input selects which overhead bytes take part. The choices are all 27 section and line bytes, the lower data-channel bytes, the upper data-channel bytes, or both data-channel groups. Each direction has its own enable. The frame logic supplies a frame-start pulse and a position strobe carrying the overhead index `row*3 + column` (0 to 26). Framing, scrambling and the byte multiplexing itself are handled outside this block. For the two parity positions the block flags the byte as an XOR mask: an all-zero byte leaves the computed parity as it is.

Top module: `oh_serial_port`

## Requirements
- R1: Both serial clocks run at the core clock divided by `DIV` (default 80). Each is high for the first `DIV/2` cycles of every bit period and low for the rest. The divider restarts with the clock high on `frame_start`.
- R2: The transmit side samples `tx_sdata` on the falling edge of `tx_sclk`. Bit 0 of a frame's group is the first bit period after `frame_start`. Each byte is assembled MSB first, and the bytes fill the selected slots in frame order.
- R3: The receive side changes `rx_sdata` only on a falling edge of `rx_sclk`. It drives the selected bytes MSB first in frame order, and drives 0 after the last bit of the group.
- R4: Byte selection by index, where index = row*3 + column. Mode 0 selects indices 0..26 (27 bytes). Mode 1 selects 6..8 (3 bytes). Mode 2 selects 15..23 (9 bytes). Mode 3 selects 6..8 then 15..23 (12 bytes). Slot numbers run in this same order starting at 0.
- R5: `tx_sync` is high for the whole first bit period of the group. `rx_sync` is high exactly while `rx_sdata` carries bit 0.
- R6: Bytes collected serially during frame N are presented in frame N+1. When `pos_valid` carries a selected index, `ins_valid`, `ins_data` and `ins_xor` follow one clock later.
- R7: A byte whose eighth bit was not sampled before the next `frame_start` is presented as 0x00.
- R8: `ins_xor` is 1 only at index 3 and index 12, the two parity bytes. The byte is passed on unchanged, so 0x00 means the parity is not altered.
- R9: `mode` is sampled on each `frame_start`. The sampled value governs receive capture during that frame. It then governs the serial group of the next frame, and transmit insertion in the frame after that.
- R10: With `tx_en` low, `tx_sclk` and `tx_sync` are low, no byte is inserted, and no byte is collected.
- R11: With `rx_en` low, `rx_sclk`, `rx_sdata` and `rx_sync` are low, and no byte is captured.
- R12: After reset all outputs are low, and nothing is inserted before the first `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| mode | input | 2 | Byte-selection mode, sampled at frame start |
| tx_en | input | 1 | Transmit (insert) direction enable |
| rx_en | input | 1 | Receive (extract) direction enable |
| pos_valid | input | 1 | An overhead position is present this cycle |
| pos_idx | input | 5 | Overhead index, row*3+column |
| ext_data | input | 8 | Byte extracted from the incoming frame at pos_idx |
| tx_sdata | input | 1 | Serial data from the external device |
| tx_sclk | output | 1 | Transmit serial clock |
| tx_sync | output | 1 | Marks the first bit period of the transmit group |
| ins_valid | output | 1 | Insert the byte on ins_data at the last strobed position |
| ins_data | output | 8 | Byte to insert, or XOR mask at a parity position |
| ins_xor | output | 1 | ins_data is an XOR mask for a parity byte |
| rx_sclk | output | 1 | Receive serial clock |
| rx_sync | output | 1 | Marks bit 0 on rx_sdata |
| rx_sdata | output | 1 | Serial data to the external device |

## Verification
Errors in the divider or bit counter show within one bit period. The clock level, the sync timing or the position of every later bit goes wrong. The bench detects this in the first frame by sampling each bit mid-window. Errors in the slot map, the buffer swap or the mode pipeline only show one or two frames later, as a wrong `ins_data` at a strobed position or a wrong receive bit. For that reason the bench keeps its own frame-delayed model and compares every strobe and every bit of every frame. Truncated frames and enable changes reveal stale buffer contents in the first frame after the change.

// File: rtl/oh_pkg.sv
// Shared constants, types and byte-selection helpers for the overhead
// serial port. Assumes a single STS-1 style overhead of 9 rows x 3 columns.
package oh_pkg;
    localparam int OH_SLOTS  = 27;
    localparam int OH_IDX_W  = 5;
    localparam int OH_BYTE_W = 8;
    localparam int OH_BIT_W  = $clog2(OH_SLOTS * OH_BYTE_W + 1);
    localparam int OH_PAR_A  = 3;   // first parity byte index
    localparam int OH_PAR_B  = 12;  // second parity byte index

    typedef enum logic [1:0] {
        OHM_ALL  = 2'd0,
        OHM_LOW  = 2'd1,
        OHM_HIGH = 2'd2,
        OHM_BOTH = 2'd3
    } ohm_e;

    typedef struct packed {
        logic                hit;
        logic [OH_IDX_W-1:0] slot;
    } oh_map_t;

    // Map an overhead index to its slot under a mode.
    function automatic oh_map_t oh_lookup(input logic [1:0] m, input logic [OH_IDX_W-1:0] idx);
        oh_map_t r;
        logic    lo, hi;
        lo = (idx >= 5'd6)  && (idx <= 5'd8);
        hi = (idx >= 5'd15) && (idx <= 5'd23);
        r  = '0;
        case (ohm_e'(m))
            OHM_ALL:  begin r.hit = (idx < 5'd27); r.slot = idx;         end
            OHM_LOW:  begin r.hit = lo;            r.slot = idx - 5'd6;  end
            OHM_HIGH: begin r.hit = hi;            r.slot = idx - 5'd15; end
            default:  begin r.hit = lo | hi;       r.slot = lo ? idx - 5'd6 : idx - 5'd12; end
        endcase
        return r;
    endfunction

    // Number of bytes per frame under a mode.
    function automatic logic [OH_IDX_W-1:0] oh_count(input logic [1:0] m);
        case (ohm_e'(m))
            OHM_ALL:  return 5'd27;
            OHM_LOW:  return 5'd3;
            OHM_HIGH: return 5'd9;
            default:  return 5'd12;
        endcase
    endfunction
endpackage

// File: rtl/oh_clkgen.sv
// Bit-period timer shared by both directions. Divides the core clock by DIV,
// restarts high on frame_start, and counts bits of the frame's byte group.
// Assumes DIV is even and at least 4.
module oh_clkgen
    import oh_pkg::*;
#(
    parameter int DIV = 80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [OH_IDX_W-1:0] nbytes,
    output logic                sclk,
    output logic                fall,
    output logic                active,
    output logic [OH_BIT_W-1:0] bitn
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    logic [CW-1:0]       cnt;
    logic [OH_BIT_W-1:0] nbits;

    assign nbits = {nbytes, 3'b000};
    assign fall  = !frame_start && (cnt == CW'(HALF - 1));

    // Divider, clock level and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sclk   <= 1'b0;
            bitn   <= '0;
            active <= 1'b0;
        end else if (frame_start) begin
            cnt    <= '0;
            sclk   <= 1'b1;
            bitn   <= '0;
            active <= 1'b1;
        end else begin
            cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
            if (cnt == CW'(DIV - 1))
                sclk <= 1'b1;
            else if (cnt == CW'(HALF - 1))
                sclk <= 1'b0;
            if (cnt == CW'(DIV - 1) && active) begin
                bitn <= bitn + 1'b1;
                if (bitn + 1'b1 == nbits)
                    active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/oh_tx_collect.sv
// Transmit side: assembles serial bits into slot bytes during one frame,
// swaps them into an insert buffer at frame start, and presents them at the
// matching overhead positions. Assumes pos_valid never coincides with frame_start.
module oh_tx_collect
    import oh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 en,
    input  logic                 fall,
    input  logic                 active,
    input  logic [OH_BIT_W-1:0]  bitn,
    input  logic                 sdata,
    input  logic [1:0]           xfer_mode,
    input  logic                 pos_valid,
    input  logic [OH_IDX_W-1:0]  pos_idx,
    output logic                 ins_valid,
    output logic [OH_BYTE_W-1:0] ins_data,
    output logic                 ins_xor
);
    logic [OH_BYTE_W-2:0] shreg;
    logic [OH_BYTE_W-1:0] cap  [OH_SLOTS];
    logic [OH_BYTE_W-1:0] ibuf [OH_SLOTS];
    logic [1:0]           ins_mode;
    logic                 live;
    oh_map_t              im;

    assign im = oh_lookup(ins_mode, pos_idx);

    // Serial capture and per-frame swap into the insert buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            ins_mode <= '0;
            live     <= 1'b0;
            for (int i = 0; i < OH_SLOTS; i++) begin
                cap[i]  <= '0;
                ibuf[i] <= '0;
            end
        end else if (frame_start) begin
            ins_mode <= xfer_mode;
            live     <= 1'b1;
            for (int i = 0; i < OH_SLOTS; i++) begin
                ibuf[i] <= cap[i];
                cap[i]  <= '0;
            end
        end else if (en && active && fall) begin
            shreg <= {shreg[OH_BYTE_W-3:0], sdata};
            if (bitn[2:0] == 3'd7)
                cap[bitn[OH_BIT_W-1:3]] <= {shreg, sdata};
        end
    end

    // Registered insert request at each strobed position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_valid <= 1'b0;
            ins_data  <= '0;
            ins_xor   <= 1'b0;
        end else begin
            ins_valid <= en && live && pos_valid && im.hit;
            ins_data  <= (en && live && pos_valid && im.hit) ? ibuf[im.slot] : '0;
            ins_xor   <= en && live && pos_valid && im.hit &&
                         (pos_idx == OH_IDX_W'(OH_PAR_A) || pos_idx == OH_IDX_W'(OH_PAR_B));
        end
    end
endmodule

// File: rtl/oh_rx_shift.sv
// Receive side: captures selected extracted bytes during one frame, swaps
// them into a shift buffer at frame start, and drives them MSB first on the
// falling edges of the next frame. Assumes pos_valid never coincides with frame_start.
module oh_rx_shift
    import oh_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 en,
    input  logic                 fall,
    input  logic                 active,
    input  logic [OH_BIT_W-1:0]  bitn,
    input  logic [1:0]           cur_mode,
    input  logic                 pos_valid,
    input  logic [OH_IDX_W-1:0]  pos_idx,
    input  logic [OH_BYTE_W-1:0] ext_data,
    output logic                 sdata,
    output logic                 sync
);
    logic [OH_BYTE_W-1:0] rcap [OH_SLOTS];
    logic [OH_BYTE_W-1:0] rbuf [OH_SLOTS];
    logic                 sd_q, sy_q;
    oh_map_t              cm;

    assign cm    = oh_lookup(cur_mode, pos_idx);
    assign sdata = en & sd_q;
    assign sync  = en & sy_q;

    // Byte capture and per-frame swap into the shift buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < OH_SLOTS; i++) begin
                rcap[i] <= '0;
                rbuf[i] <= '0;
            end
        end else if (frame_start) begin
            for (int i = 0; i < OH_SLOTS; i++) begin
                rbuf[i] <= rcap[i];
                rcap[i] <= '0;
            end
        end else if (en && pos_valid && cm.hit) begin
            rcap[cm.slot] <= ext_data;
        end
    end

    // Drive the next bit and its sync on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= 1'b0;
            sy_q <= 1'b0;
        end else if (fall) begin
            if (en && active) begin
                sd_q <= rbuf[bitn[OH_BIT_W-1:3]][3'd7 - bitn[2:0]];
                sy_q <= (bitn == '0);
            end else begin
                sd_q <= 1'b0;
                sy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/oh_serial_port.sv
// Top of the overhead serial port. Holds the mode pipeline and ties the shared
// bit timer to the transmit collector and receive shifter. Assumes one
// frame_start per frame and a frame long enough for the selected group.
module oh_serial_port
    import oh_pkg::*;
#(
    parameter int DIV = 80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic [1:0]           mode,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic                 pos_valid,
    input  logic [OH_IDX_W-1:0]  pos_idx,
    input  logic [OH_BYTE_W-1:0] ext_data,
    input  logic                 tx_sdata,
    output logic                 tx_sclk,
    output logic                 tx_sync,
    output logic                 ins_valid,
    output logic [OH_BYTE_W-1:0] ins_data,
    output logic                 ins_xor,
    output logic                 rx_sclk,
    output logic                 rx_sync,
    output logic                 rx_sdata
);
    logic [1:0]          cur_mode, xfer_mode;
    logic                sclk, fall, active;
    logic [OH_BIT_W-1:0] bitn;

    // Mode pipeline: capture mode, then serial-group mode one frame later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode  <= '0;
            xfer_mode <= '0;
        end else if (frame_start) begin
            cur_mode  <= mode;
            xfer_mode <= cur_mode;
        end
    end

    oh_clkgen #(.DIV(DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .nbytes(oh_count(xfer_mode)),
        .sclk(sclk), .fall(fall), .active(active), .bitn(bitn)
    );

    oh_tx_collect u_tx (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .en(tx_en),
        .fall(fall), .active(active), .bitn(bitn), .sdata(tx_sdata),
        .xfer_mode(xfer_mode), .pos_valid(pos_valid), .pos_idx(pos_idx),
        .ins_valid(ins_valid), .ins_data(ins_data), .ins_xor(ins_xor)
    );

    oh_rx_shift u_rx (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .en(rx_en),
        .fall(fall), .active(active), .bitn(bitn), .cur_mode(cur_mode),
        .pos_valid(pos_valid), .pos_idx(pos_idx), .ext_data(ext_data),
        .sdata(rx_sdata), .sync(rx_sync)
    );

    assign tx_sclk = tx_en & sclk;
    assign rx_sclk = rx_en & sclk;
    assign tx_sync = tx_en & active & (bitn == '0);
endmodule

// File: rtl/oh_port_chk.sv
// Port-level protocol checks for oh_serial_port, attached by bind.
module oh_port_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic rx_en,
    input logic pos_valid,
    input logic tx_sclk,
    input logic tx_sync,
    input logic ins_valid,
    input logic ins_xor,
    input logic rx_sclk,
    input logic rx_sync,
    input logic rx_sdata
);
    AST_TX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!tx_sclk && !tx_sync)); // R10

    AST_TX_OFF_NO_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !$past(tx_en)) |-> !ins_valid); // R10

    AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> (!rx_sclk && !rx_sdata && !rx_sync)); // R11

    AST_RX_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $past(rx_en) && !$stable(rx_sdata)) |-> ($past(rx_sclk) && !rx_sclk)); // R3

    AST_XOR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ins_xor |-> ins_valid); // R8

    AST_INSERT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> ($past(pos_valid) && $past(tx_en))); // R6
endmodule

bind oh_serial_port oh_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .pos_valid(pos_valid), .tx_sclk(tx_sclk), .tx_sync(tx_sync),
    .ins_valid(ins_valid), .ins_xor(ins_xor), .rx_sclk(rx_sclk),
    .rx_sync(rx_sync), .rx_sdata(rx_sdata)
);

// File: tb/tb_oh_serial_port.sv
module tb_oh_serial_port;
    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;
    localparam int FLEN = 27 * 8 * DIV + 2 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic tx_en = 1'b0, rx_en = 1'b0;
    logic pos_valid = 1'b0;
    logic [4:0] pos_idx = '0;
    logic [7:0] ext_data = '0;
    logic tx_sdata = 1'b0;
    logic tx_sclk, tx_sync, ins_valid, ins_xor, rx_sclk, rx_sync, rx_sdata;
    logic [7:0] ins_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    oh_serial_port #(.DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode(mode),
        .tx_en(tx_en), .rx_en(rx_en), .pos_valid(pos_valid), .pos_idx(pos_idx),
        .ext_data(ext_data), .tx_sdata(tx_sdata), .tx_sclk(tx_sclk),
        .tx_sync(tx_sync), .ins_valid(ins_valid), .ins_data(ins_data),
        .ins_xor(ins_xor), .rx_sclk(rx_sclk), .rx_sync(rx_sync), .rx_sdata(rx_sdata)
    );

    // Model state
    logic [7:0] sent [27];
    logic [7:0] ext  [27];
    logic [7:0] tcap [27];
    logic [7:0] ibuf [27];
    logic [7:0] rcap [27];
    logic [7:0] rbuf [27];
    int  cur = 0, xf = 0, imode = 0;
    bit  live = 0;
    bit  e_v = 0, e_x = 0;
    logic [7:0] e_d = '0;

    function automatic bit m_hit(int m, int idx);
        if (m == 0) return idx < 27;
        if (m == 1) return idx >= 6 && idx <= 8;
        if (m == 2) return idx >= 15 && idx <= 23;
        return (idx >= 6 && idx <= 8) || (idx >= 15 && idx <= 23);
    endfunction

    function automatic int m_slot(int m, int idx);
        if (m == 0) return idx;
        if (m == 2) return idx - 15;
        if (idx <= 8) return idx - 6;
        return (m == 1) ? idx - 6 : idx - 12;
    endfunction

    function automatic int m_nb(int m);
        case (m)
            0: return 27;
            1: return 3;
            2: return 9;
            default: return 12;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_frame(input int len, input int m, input bit te, input bit re);
        int nbits;
        for (int k = 0; k < 27; k++) begin
            ibuf[k] = tcap[k];
            rbuf[k] = rcap[k];
            tcap[k] = '0;
            rcap[k] = '0;
            sent[k] = 8'($urandom);
            ext[k]  = 8'($urandom);
        end
        imode = xf; xf = cur; cur = m; live = 1;
        nbits = 8 * m_nb(xf);
        for (int cyc = 0; cyc < len; cyc++) begin
            @(negedge clk);
            // insert outputs from the previous strobe: R6 R8
            chk("R6 ins_valid", int'(ins_valid), int'(e_v));
            if (e_v) begin
                chk("R6 R7 ins_data", int'(ins_data), int'(e_d));
                chk("R8 ins_xor", int'(ins_xor), int'(e_x));
            end
            // clock shape and tx sync: R1 R5 R10
            if (cyc == 2) begin
                chk("R1 tx_sclk high", int'(tx_sclk), int'(te));
                chk("R1 rx_sclk high", int'(rx_sclk), int'(re));
                chk("R5 tx_sync first bit", int'(tx_sync), int'(te));
            end
            if (cyc == HALF + 2) chk("R1 tx_sclk low", int'(tx_sclk), 0);
            if (cyc == DIV + 2) begin
                chk("R1 tx_sclk next period", int'(tx_sclk), int'(te));
                chk("R5 tx_sync cleared", int'(tx_sync), 0);
            end
            // receive bits mid-window: R3 R4 R5 R11
            if (cyc >= HALF + 2 && (cyc - HALF - 2) % DIV == 0) begin
                int b;
                b = (cyc - HALF - 2) / DIV;
                if (b <= nbits) begin
                    int eb;
                    eb = (re && b < nbits) ? int'(rbuf[b / 8][7 - b % 8]) : 0;
                    chk("R3 R4 rx_sdata", int'(rx_sdata), eb);
                    chk("R5 R11 rx_sync", int'(rx_sync), (re && b == 0) ? 1 : 0);
                end
            end
            // drive
            frame_start = (cyc == 0);
            if (cyc == 0) begin
                mode = 2'(m);
                tx_en = te;
                rx_en = re;
            end
            if (cyc >= 1) begin
                int b;
                b = (cyc - 1) / DIV;
                tx_sdata = (b < 216) ? sent[b / 8][7 - b % 8] : 1'b0;
            end
            e_v = 0; e_x = 0; e_d = '0;
            pos_valid = 1'b0;
            if (cyc >= 5 && (cyc - 5) % 7 == 0 && (cyc - 5) / 7 < 27) begin
                int idx;
                idx = (cyc - 5) / 7;
                pos_valid = 1'b1;
                pos_idx = 5'(idx);
                ext_data = ext[idx];
                if (te && live && m_hit(imode, idx)) begin
                    e_v = 1;
                    e_d = ibuf[m_slot(imode, idx)];
                    e_x = (idx == 3 || idx == 12);
                end
                if (re && m_hit(cur, idx)) rcap[m_slot(cur, idx)] = ext[idx];
            end
        end
        // transmit bytes completed within this frame: R2 R7
        for (int k = 0; k < m_nb(xf); k++)
            if (te && (8 * k + 7) * DIV + HALF <= len - 1) tcap[k] = sent[k];
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 27; k++) begin
            tcap[k] = '0; rcap[k] = '0;
        end
        repeat (4) @(negedge clk);
        // R12: reset state
        chk("R12 tx_sclk", int'(tx_sclk), 0);
        chk("R12 rx_sclk", int'(rx_sclk), 0);
        chk("R12 rx_sdata", int'(rx_sdata), 0);
        chk("R12 ins_valid", int'(ins_valid), 0);
        rst_n = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
        pos_valid = 1'b1; pos_idx = 5'd3;
        @(negedge clk);
        pos_valid = 1'b0;
        @(negedge clk);
        chk("R12 no insert before frame", int'(ins_valid), 0);
        chk("R12 tx_sync before frame", int'(tx_sync), 0);
        // each mode held steady (R4 R9)
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 3; f++) run_frame(FLEN, m, 1, 1);
        // truncated frame, missing bytes become zero (R7)
        run_frame(FLEN, 0, 1, 1);
        run_frame(80 * DIV + 3, 0, 1, 1);
        run_frame(FLEN, 0, 1, 1);
        run_frame(FLEN, 0, 1, 1);
        // transmit disabled then re-enabled (R10)
        run_frame(FLEN, 3, 0, 1);
        run_frame(FLEN, 3, 0, 1);
        run_frame(FLEN, 3, 1, 1);
        run_frame(FLEN, 3, 1, 1);
        // receive disabled then re-enabled (R11)
        run_frame(FLEN, 2, 1, 0);
        run_frame(FLEN, 2, 1, 0);
        run_frame(FLEN, 2, 1, 1);
        run_frame(FLEN, 2, 1, 1);
        // mode changing every frame (R9)
        for (int f = 0; f < 5; f++) run_frame(FLEN, int'($urandom % 4), 1, 1);
        @(negedge clk);
        chk("R6 ins_valid tail", int'(ins_valid), int'(e_v));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule